// File: doc/BRIEF.md
# Six-Channel Down-Counting Timer Unit

This peripheral provides six independent 32-bit down-counters behind a simple synchronous register bus. The timers are built as three identical pairs, and each pair occupies its own window in the address map. Each timer has four registers. A control word picks where counts come from: every clock cycle, or edges of a per-timer event pin, with optional two-stage synchronisation. A run register starts and stops the timer and can request a load. A reload register holds the restart value, and a count register shows the live value.

When a running timer steps from one to zero, it latches a bit in a shared capture register. On its next count event it restarts from the reload value. Each captured bit is gated by a matching enable bit to drive that timer's interrupt line, and software clears captured bits by writing ones. A unit-wide clock-control register freezes all counting while the unit is disabled or suspended. A read-only identification register lets software confirm that the unit is present.

Top module: `sixch_timer_unit`

## Requirements
- R1: After reset every register reads zero except the identification register, and all interrupt outputs are low.
- R2: Address 0x08 reads 0x0000_5900 (constant 0x59 in bits 15:8), and writes to it have no effect.
- R3: Timer n's registers start at 0x10 + 0x20*(n/2) + 4*(n%2), with control at +0x00, run at +0x08, reload at +0x10 and count at +0x18. Writing each timer touches only that timer. The control word keeps only bits 2, 6, 7, 8 and 10; all other bits read zero.
- R4: Clock control sits at 0x00 and keeps bits 0, 4 and 8. Timers count only while bit 0 (disable) is 0 and bit 4 (out of suspend) is 1. Bit 8 (run mode) is stored and read back only.
- R5: A run-register write sets the run state from bit 0. If bit 2 is set, the same write loads the reload value into the counter, and this load takes priority over counting in that cycle. The run register reads back the run state in bit 0 only.
- R6: When control bit 10 is set, a running timer in an active unit decrements by one on every clock cycle.
- R7: A count event at value 1 brings the counter to 0 and sets capture bit n in the same cycle. The next count event at value 0 reloads the counter from the reload register.
- R8: Writing 0 to the run register stops the timer, and the count then holds.
- R9: When control bit 10 is clear and bit 2 is set, the timer counts edges of its event input. Bits 7:6 pick the edge: 01 rising, 10 falling, 11 both, 00 none. Bit 8 adds one more synchronising stage.
- R10: Interrupt enable sits at 0xF4 with bit n for timer n. Interrupt output n is high exactly when capture bit n and enable bit n are both set.
- R11: Capture sits at 0xFC. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R12: Address 0xF8, unmapped addresses and misaligned addresses read zero and ignore writes. The count register is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current address |
| evt_in | input | 6 | Per-timer external event pins |
| irq | output | 6 | Per-timer interrupt outputs |

## Verification
The assertions assume at most one bus access per cycle. They also assume that the reload register and the run register of the same timer are never written together, since they sit at different addresses and the bus allows only one. Event pins are treated as asynchronous but slow: a level must be held for at least three clock cycles, or synchronised edges would be lost. The bench drives every access at the falling edge and holds each event-pin level for four cycles before checking.

// File: rtl/tmu_pkg.sv
// Package: shared constants for the six-channel timer unit.
// Assumes a byte-addressed bus with word-aligned 32-bit registers.
package tmu_pkg;
    localparam int ADDR_CLKCTL  = 8'h00;
    localparam int ADDR_IDENT   = 8'h08;
    localparam int ADDR_TMR_LO  = 8'h10;
    localparam int PAIR_STRIDE  = 8'h20;
    localparam int ADDR_IRQ_EN  = 8'hF4;
    localparam int ADDR_IRQ_CTL = 8'hF8;
    localparam int ADDR_IRQ_CAP = 8'hFC;

    localparam logic [7:0] IDENT_CODE = 8'h59;

    localparam logic [31:0] CLKCTL_MASK = 32'h0000_0111;
    localparam int CLKCTL_DIS   = 0;
    localparam int CLKCTL_AWAKE = 4;

    localparam logic [31:0] CTRL_MASK = 32'h0000_05C4;
    localparam int CTRL_EXT_EN   = 2;
    localparam int CTRL_EDGE_LO  = 6;
    localparam int CTRL_SYNC     = 8;
    localparam int CTRL_INT_CLK  = 10;

    localparam int RUN_GO   = 0;
    localparam int RUN_LOAD = 2;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RUN    = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_COUNT  = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/tmu_evt_edge.sv
// Module: event-pin synchroniser and edge selector for one timer.
// Assumes din is asynchronous and each level lasts at least three cycles.
module tmu_evt_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic       sync_en,
    input  logic [1:0] edge_sel,
    output logic       evt
);
    logic s1_q, s2_q, last_q, sample;

    assign sample = sync_en ? s2_q : s1_q;

    // Capture the pin through one or two stages and keep the prior sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            last_q <= 1'b0;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            last_q <= sample;
        end
    end

    // Raise one event per selected edge of the chosen sample.
    always_comb begin
        evt = (edge_sel[0] & sample & ~last_q) | (edge_sel[1] & ~sample & last_q);
    end
endmodule

// File: rtl/tmu_timer.sv
// Module: one down-counting timer with control, run, reload and count state.
// Assumes the reload and run registers are never written in the same cycle.
module tmu_timer #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ctrl_we,
    input  logic              run_we,
    input  logic              rld_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_in,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              run_q,
    output logic [CNT_W-1:0]  rld_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              expire
);
    import tmu_pkg::*;

    logic ext_evt, count_evt, step, load_req;

    tmu_evt_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ext_in),
        .sync_en  (ctrl_q[CTRL_SYNC]),
        .edge_sel (ctrl_q[CTRL_EDGE_LO+1:CTRL_EDGE_LO]),
        .evt      (ext_evt)
    );

    // Pick the count source and qualify it with run and unit state.
    always_comb begin
        count_evt = ctrl_q[CTRL_INT_CLK] | (ctrl_q[CTRL_EXT_EN] & ext_evt);
        load_req  = run_we & wdata[RUN_LOAD];
        step      = run_q & active & count_evt;
        expire    = step & ~load_req & (cnt_q == CNT_W'(1));
    end

    // Hold the software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            run_q  <= 1'b0;
            rld_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= wdata & DATA_W'(CTRL_MASK);
            if (run_we)  run_q  <= wdata[RUN_GO];
            if (rld_we)  rld_q  <= wdata[CNT_W-1:0];
        end
    end

    // Load, decrement or wrap the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_req) begin
            cnt_q <= rld_q;
        end else if (step) begin
            if (cnt_q == '0) cnt_q <= rld_q;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_req) |=> (cnt_q == $past(cnt_q)));
    p_freeze_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load_req) |=> (cnt_q == $past(cnt_q)));
    p_load_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (cnt_q == $past(rld_q)));
    p_wrap_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_req && cnt_q == '0) |=> (cnt_q == $past(rld_q)));
endmodule

// File: rtl/tmu_irq_ctl.sv
// Module: per-timer interrupt enable and write-one-to-clear capture latch.
// Assumes expire pulses last one cycle; a set beats a same-cycle clear.
module tmu_irq_ctl #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         cap_we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] expire,
    output logic [N-1:0] en_q,
    output logic [N-1:0] cap_q,
    output logic [N-1:0] irq
);
    logic [N-1:0] clr_mask;

    // Form the clear mask from a capture-register write.
    always_comb begin
        clr_mask = cap_we ? wdata : '0;
        irq      = cap_q & en_q;
    end

    // Store enables and latch expiry events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            cap_q <= '0;
        end else begin
            if (en_we) en_q <= wdata;
            cap_q <= (cap_q & ~clr_mask) | expire;
        end
    end

    p_cap_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((cap_q & $past(expire)) == $past(expire)));
    p_cap_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(cap_q) & ~$past(clr_mask)) & ~cap_q) == '0));
endmodule

// File: rtl/sixch_timer_unit.sv
// Module: top of the six-channel timer unit: decode, clock control, read mux.
// Assumes one bus access per cycle and word-aligned register addresses.
module sixch_timer_unit #(
    parameter int N_TIMERS = 6,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_TIMERS-1:0] evt_in,
    output logic [N_TIMERS-1:0] irq
);
    import tmu_pkg::*;

    localparam int N_PAIRS  = (N_TIMERS + 1) / 2;
    localparam int CH_W     = 3;
    localparam int TMR_HI   = ADDR_TMR_LO + N_PAIRS * PAIR_STRIDE;

    logic [6:0]        rel;
    logic              in_tmr, wr_en, rd_en;
    logic [CH_W-1:0]   ch;
    tmr_reg_e          rsel;
    logic [DATA_W-1:0] clk_ctl_q;
    logic              active;

    logic [DATA_W-1:0] t_ctrl [N_TIMERS];
    logic              t_run  [N_TIMERS];
    logic [CNT_W-1:0]  t_rld  [N_TIMERS];
    logic [CNT_W-1:0]  t_cnt  [N_TIMERS];
    logic [N_TIMERS-1:0] t_exp;
    logic [N_TIMERS-1:0] en_q, cap_q;

    // Split the address into pair, member and register fields.
    always_comb begin
        wr_en  = bus_sel & bus_wr;
        rd_en  = bus_sel & ~bus_wr;
        rel    = 7'(bus_addr - ADDR_W'(ADDR_TMR_LO));
        in_tmr = (bus_addr >= ADDR_W'(ADDR_TMR_LO)) && (bus_addr < ADDR_W'(TMR_HI))
                 && (rel[1:0] == 2'b00) && ((rel[6:5] * 2 + rel[2]) < N_TIMERS);
        ch     = {rel[6:5], rel[2]};
        rsel   = tmr_reg_e'(rel[4:3]);
        active = ~clk_ctl_q[CLKCTL_DIS] & clk_ctl_q[CLKCTL_AWAKE];
    end

    // Hold the unit clock-control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_ctl_q <= '0;
        else if (wr_en && bus_addr == ADDR_W'(ADDR_CLKCTL))
            clk_ctl_q <= bus_wdata & DATA_W'(CLKCTL_MASK);
    end

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        logic hit;
        assign hit = wr_en & in_tmr & (ch == CH_W'(i));
        tmu_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active),
            .ctrl_we (hit & (rsel == SEL_CTRL)),
            .run_we  (hit & (rsel == SEL_RUN)),
            .rld_we  (hit & (rsel == SEL_RELOAD)),
            .wdata   (bus_wdata),
            .ext_in  (evt_in[i]),
            .ctrl_q  (t_ctrl[i]),
            .run_q   (t_run[i]),
            .rld_q   (t_rld[i]),
            .cnt_q   (t_cnt[i]),
            .expire  (t_exp[i])
        );
    end

    tmu_irq_ctl #(.N(N_TIMERS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_we  (wr_en && bus_addr == ADDR_W'(ADDR_IRQ_EN)),
        .cap_we (wr_en && bus_addr == ADDR_W'(ADDR_IRQ_CAP)),
        .wdata  (bus_wdata[N_TIMERS-1:0]),
        .expire (t_exp),
        .en_q   (en_q),
        .cap_q  (cap_q),
        .irq    (irq)
    );

    // Select read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (in_tmr) begin
                for (int i = 0; i < N_TIMERS; i++) begin
                    if (ch == CH_W'(i)) begin
                        case (rsel)
                            SEL_CTRL:   bus_rdata = t_ctrl[i];
                            SEL_RUN:    bus_rdata = DATA_W'(t_run[i]);
                            SEL_RELOAD: bus_rdata = DATA_W'(t_rld[i]);
                            default:    bus_rdata = DATA_W'(t_cnt[i]);
                        endcase
                    end
                end
            end else if (bus_addr == ADDR_W'(ADDR_CLKCTL)) begin
                bus_rdata = clk_ctl_q;
            end else if (bus_addr == ADDR_W'(ADDR_IDENT)) begin
                bus_rdata = DATA_W'({IDENT_CODE, 8'h00});
            end else if (bus_addr == ADDR_W'(ADDR_IRQ_EN)) begin
                bus_rdata = DATA_W'(en_q);
            end else if (bus_addr == ADDR_W'(ADDR_IRQ_CAP)) begin
                bus_rdata = DATA_W'(cap_q);
            end
        end
    end

    p_ident_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(ADDR_IDENT)) |-> (bus_rdata == DATA_W'(32'h5900)));
    p_irq_ctl_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(ADDR_IRQ_CTL)) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_sixch_timer_unit.sv
module sim_sixch_timer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_in = '0;
    logic [5:0]  irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sixch_timer_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    function automatic logic [7:0] ra(input int n, input int r);
        return 8'(16 + 32 * (n / 2) + 4 * (n % 2) + 8 * r);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; one rising edge passes.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); chk("R1 clkctl", d, 0);
        rd(8'hF4, d); chk("R1 enable", d, 0);
        rd(8'hFC, d); chk("R1 capture", d, 0);
        for (int n = 0; n < 6; n++) begin
            rd(ra(n, 2), d); chk("R1 reload", d, 0);
            rd(ra(n, 3), d); chk("R1 count", d, 0);
        end
        chk("R1 irq", {26'd0, irq}, 0);
    endtask

    task automatic t_ident;
        logic [31:0] d;
        rd(8'h08, d); chk("R2 ident", d, 32'h5900);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R2 ident after write", d, 32'h5900);
    endtask

    task automatic t_map;
        logic [31:0] d;
        for (int n = 0; n < 6; n++) wr(ra(n, 2), 32'h1000_0000 + 32'(n * 32'h111));
        for (int n = 0; n < 6; n++) begin
            rd(ra(n, 2), d); chk("R3 reload map", d, 32'h1000_0000 + 32'(n * 32'h111));
        end
        wr(ra(5, 0), 32'hFFFF_FFFF);
        rd(ra(5, 0), d); chk("R3 ctrl mask", d, 32'h0000_05C4);
        rd(ra(4, 0), d); chk("R3 ctrl neighbour", d, 0);
        wr(ra(5, 0), 0);
    endtask

    task automatic t_clkctl;
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R4 clkctl mask", d, 32'h111);
        wr(8'h00, 32'h110);
        wr(ra(2, 0), 32'h400);
        wr(ra(2, 2), 50);
        wr(ra(2, 1), 5);
        rd(ra(2, 1), d); chk("R5 run readback", d, 1);
        wr(8'h00, 32'h111);
        rd(ra(2, 3), d); chk("R4 last count before disable", d, 49);
        tick(3);
        rd(ra(2, 3), d); chk("R4 frozen while disabled", d, 49);
        wr(8'h00, 32'h100);
        tick(2);
        rd(ra(2, 3), d); chk("R4 frozen while suspended", d, 49);
        wr(8'h00, 32'h110);
        tick(1);
        rd(ra(2, 3), d); chk("R4 resumes", d, 48);
        wr(ra(2, 1), 5);
        rd(ra(2, 3), d); chk("R5 load wins over count", d, 50);
        wr(ra(2, 1), 0);
    endtask

    task automatic t_expire;
        logic [31:0] d;
        wr(8'hF4, 32'h1);
        wr(ra(0, 0), 32'h400);
        wr(ra(0, 2), 3);
        wr(ra(0, 1), 5);
        rd(ra(0, 3), d); chk("R5 loaded on start", d, 3);
        tick(2);
        rd(ra(0, 3), d); chk("R6 two decrements", d, 1);
        rd(8'hFC, d); chk("R7 no capture yet", d, 0);
        tick(1);
        rd(ra(0, 3), d); chk("R7 reaches zero", d, 0);
        rd(8'hFC, d); chk("R7 capture set", d, 1);
        chk("R10 irq on", {26'd0, irq}, 1);
        tick(1);
        rd(ra(0, 3), d); chk("R7 auto reload", d, 3);
        wr(ra(0, 1), 0);
        rd(ra(0, 3), d); chk("R8 stopped", d, 2);
        tick(3);
        rd(ra(0, 3), d); chk("R8 holds", d, 2);
        wr(8'hF4, 0);
        chk("R10 irq gated off", {26'd0, irq}, 0);
        rd(8'hFC, d); chk("R10 capture kept", d, 1);
        wr(8'hFC, 0);
        rd(8'hFC, d); chk("R11 write zero keeps", d, 1);
        wr(8'hFC, 32'h3E);
        rd(8'hFC, d); chk("R11 other bits keep", d, 1);
        wr(8'hFC, 1);
        rd(8'hFC, d); chk("R11 write one clears", d, 0);
    endtask

    task automatic t_ext;
        logic [31:0] d;
        wr(ra(3, 0), 32'h044);
        wr(ra(3, 2), 10);
        wr(ra(3, 1), 5);
        evt_in[3] = 1'b1; tick(4);
        rd(ra(3, 3), d); chk("R9 rising counted", d, 9);
        evt_in[3] = 1'b0; tick(4);
        rd(ra(3, 3), d); chk("R9 falling ignored", d, 9);
        wr(ra(3, 0), 32'h1C4);
        evt_in[3] = 1'b1; tick(4);
        rd(ra(3, 3), d); chk("R9 any edge rise", d, 8);
        evt_in[3] = 1'b0; tick(4);
        rd(ra(3, 3), d); chk("R9 any edge fall", d, 7);
        wr(ra(3, 0), 32'h004);
        evt_in[3] = 1'b1; tick(4);
        evt_in[3] = 1'b0; tick(4);
        rd(ra(3, 3), d); chk("R9 no edge selected", d, 7);
        wr(ra(3, 1), 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(8'hF8, 32'hFFFF_FFFF);
        rd(8'hF8, d); chk("R12 irq ctl reads zero", d, 0);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, d); chk("R12 unmapped", d, 0);
        rd(8'h11, d); chk("R12 misaligned", d, 0);
        rd(8'h04, d); chk("R12 gap", d, 0);
        wr(ra(0, 3), 32'h1234);
        rd(ra(0, 3), d); chk("R12 count read-only", d, 2);
        rd(8'hFC, d); chk("R12 capture untouched", d, 0);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_map();
        t_clkctl();
        t_expire();
        t_ext();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule